// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits on the byte-write command path of a byte-wide nonvolatile memory with a 13-bit address. For every write strobe it decides, in the same cycle, whether the byte may proceed to the page buffer. It also watches the address/data pairs for two fixed command sequences. A three-write preamble turns write protection on. A six-write sequence turns it off. The page buffer, the array and the byte-load timer are outside the block. The timer reports through `load_timeout` when the load window after the last write has expired.

While protection is on, a burst of writes is accepted only if it is opened by the three-write preamble. The burst stays open until the next load timeout. The protection flag stands in for a nonvolatile bit. The ordinary reset `rst` never touches it. Only the separate power-on clear `nv_clr` returns it to its shipped state, which is unprotected.

Top module: `swp_seq`

## Requirements
- R1: After `nv_clr`, `prot_on` is 0. After `rst`, the tracker is idle and no burst is open.
- R2: The three writes 0xAA@0x1555, 0x55@0x0AAA, 0xA0@0x1555, in that order, set `prot_on` to 1 in the cycle after the third write. Protection holds even if no data write follows.
- R3: While `prot_on` is 1, a write passes only after a completed preamble. The burst stays open until a `load_timeout` cycle.
- R4: The six writes 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 clear `prot_on` in the cycle after the sixth write. Later writes pass.
- R5: A write that is not the expected next command returns the tracker to idle. If that write is itself 0xAA@0x1555, it counts as the first step of a new sequence. The mismatching write passes or is blocked according to the current protection state.
- R6: A `load_timeout` returns the tracker to idle and closes any open burst. A strobe in the same cycle is judged from idle with the burst closed.
- R7: `rst` leaves `prot_on` unchanged.
- R8: While `prot_on` is 0, every write passes, including command writes. While it is 1, the preamble writes themselves are blocked.
- R9: `wr_pass` is 0 in any cycle without `wr_stb`. `prot_on` changes only the cycle after the write that completes a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the tracker and burst state |
| nv_clr | input | 1 | Synchronous power-on clear of the protection flag |
| wr_stb | input | 1 | Byte write strobe, one cycle per byte |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| load_timeout | input | 1 | Byte-load window expired |
| prot_on | output | 1 | Protection state |
| wr_pass | output | 1 | Current write may reach the page buffer |

## Verification
`wr_pass` is combinational from the strobe and the registered state. The bench therefore drives each write just after a falling edge and samples `wr_pass` one nanosecond later, before the rising edge that consumes the write. `prot_on` comes out of a register. It is sampled one nanosecond after the rising edge that takes the completing command, which is zero cycles of latency after the write is registered. The reference model advances its own sequence step, burst flag and protection flag at that same rising edge, so each comparison sees the state the requirements predict for that cycle.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CMD_ADDR_HI = 13'h1555;
    localparam logic [ADDR_W-1:0] CMD_ADDR_LO = 13'h0AAA;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] OP_ARM     = 8'hA0;
    localparam logic [DATA_W-1:0] OP_ERASE   = 8'h80;
    localparam logic [DATA_W-1:0] OP_CLEAR   = 8'h20;

    // Sequence tracker position: which command was last accepted
    typedef enum logic [2:0] {
        TRK_IDLE  = 3'd0,
        TRK_KEY1  = 3'd1,
        TRK_KEY2  = 3'd2,
        TRK_ERASE = 3'd3,
        TRK_KEY4  = 3'd4,
        TRK_KEY5  = 3'd5
    } trk_state_e;

    // Which command pattern the present write matches
    typedef struct packed {
        logic key_first;
        logic key_second;
        logic op_arm;
        logic op_erase;
        logic op_clear;
    } cmd_hit_t;

    function automatic logic pair_eq(
        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
        input logic [ADDR_W-1:0] ca, input logic [DATA_W-1:0] cd);
        return (a == ca) && (d == cd);
    endfunction

endpackage

// File: rtl/swp_cmd_decode.sv
module swp_cmd_decode
    import swp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_hit_t          hit
);
    always_comb begin
        hit.key_first  = pair_eq(addr, data, CMD_ADDR_HI, KEY_FIRST);
        hit.key_second = pair_eq(addr, data, CMD_ADDR_LO, KEY_SECOND);
        hit.op_arm     = pair_eq(addr, data, CMD_ADDR_HI, OP_ARM);
        hit.op_erase   = pair_eq(addr, data, CMD_ADDR_HI, OP_ERASE);
        hit.op_clear   = pair_eq(addr, data, CMD_ADDR_HI, OP_CLEAR);
    end
endmodule

// File: rtl/swp_tracker.sv
module swp_tracker
    import swp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stb,
    input  logic     timeout,
    input  cmd_hit_t hit,
    output logic     burst_open,
    output logic     set_prot,
    output logic     clr_prot
);
    trk_state_e state_q, state_d, st_eff;
    logic       burst_q, burst_d;
    logic       set_raw, clr_raw;

    always_comb begin
        st_eff     = timeout ? TRK_IDLE : state_q;
        burst_open = burst_q & ~timeout;
        state_d    = st_eff;
        burst_d    = burst_open;
        set_raw    = 1'b0;
        clr_raw    = 1'b0;
        if (stb) begin
            // a mismatch falls back to idle, or restarts on the first key
            state_d = hit.key_first ? TRK_KEY1 : TRK_IDLE;
            case (st_eff)
                TRK_KEY1:  if (hit.key_second) state_d = TRK_KEY2;
                TRK_KEY2: begin
                    if (hit.op_arm) begin
                        state_d = TRK_IDLE;
                        set_raw = 1'b1;
                        burst_d = 1'b1;
                    end else if (hit.op_erase) begin
                        state_d = TRK_ERASE;
                    end
                end
                TRK_ERASE: if (hit.key_first) state_d = TRK_KEY4;
                TRK_KEY4:  if (hit.key_second) state_d = TRK_KEY5;
                TRK_KEY5: begin
                    if (hit.op_clear) begin
                        state_d = TRK_IDLE;
                        clr_raw = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign set_prot = set_raw & ~rst;
    assign clr_prot = clr_raw & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            burst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            burst_q <= burst_d;
        end
    end
endmodule

// File: rtl/swp_nv_flag.sv
module swp_nv_flag (
    input  logic clk,
    input  logic nv_clr,
    input  logic set_prot,
    input  logic clr_prot,
    output logic prot_q
);
    // Only the power-on clear resets this bit; the tracker reset does not.
    always_ff @(posedge clk) begin
        if (nv_clr)        prot_q <= 1'b0;
        else if (set_prot) prot_q <= 1'b1;
        else if (clr_prot) prot_q <= 1'b0;
    end
endmodule

// File: rtl/swp_seq.sv
module swp_seq
    import swp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nv_clr,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_timeout,
    output logic              prot_on,
    output logic              wr_pass
);
    cmd_hit_t hit;
    logic     burst_open, set_prot, clr_prot;

    swp_cmd_decode u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    swp_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .stb        (wr_stb),
        .timeout    (load_timeout),
        .hit        (hit),
        .burst_open (burst_open),
        .set_prot   (set_prot),
        .clr_prot   (clr_prot)
    );

    swp_nv_flag u_flag (
        .clk      (clk),
        .nv_clr   (nv_clr),
        .set_prot (set_prot),
        .clr_prot (clr_prot),
        .prot_q   (prot_on)
    );

    assign wr_pass = wr_stb & (~prot_on | burst_open);
endmodule

// File: rtl/swp_seq_chk.sv
module swp_seq_chk
    import swp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              nv_clr,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              load_timeout,
    input logic              prot_on,
    input logic              wr_pass
);
    logic seen0 = 1'b0;
    logic live  = 1'b0;

    always_ff @(posedge clk) begin
        if (nv_clr) seen0 <= 1'b1;
        live <= seen0;
    end

    // R2: protection only rises after the arming write
    a_r2_rise_on_arm: assert property (@(posedge clk) disable iff (nv_clr || !live)
        $rose(prot_on) |-> $past(wr_stb && !rst && !load_timeout &&
                                 wr_addr == CMD_ADDR_HI && wr_data == OP_ARM));

    // R4: protection only falls after the clearing write
    a_r4_fall_on_clear: assert property (@(posedge clk) disable iff (nv_clr || !live)
        $fell(prot_on) |-> $past(wr_stb && !rst && wr_addr == CMD_ADDR_HI && wr_data == OP_CLEAR));

    // R7: tracker reset keeps the flag
    a_r7_rst_keeps_flag: assert property (@(posedge clk) disable iff (nv_clr || !live)
        (rst && !nv_clr) |=> $stable(prot_on));

    // R8: unprotected writes always pass
    a_r8_open_passes: assert property (@(posedge clk) disable iff (nv_clr || !live || rst)
        (wr_stb && !prot_on) |-> wr_pass);

    // R9: no strobe, no pass
    a_r9_no_stb_no_pass: assert property (@(posedge clk) disable iff (nv_clr || !live)
        !wr_stb |-> !wr_pass);

    // R6: a timeout closes the burst for the next write
    a_r6_timeout_closes: assert property (@(posedge clk) disable iff (nv_clr || !live || rst)
        ($past(load_timeout) && prot_on && wr_stb) |-> !wr_pass);

endmodule

bind swp_seq swp_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .nv_clr       (nv_clr),
    .wr_stb       (wr_stb),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .load_timeout (load_timeout),
    .prot_on      (prot_on),
    .wr_pass      (wr_pass)
);

// File: tb/swp_seq_tb.sv
module swp_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        nv_clr = 1'b0;
    logic        wr_stb = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_timeout = 1'b0;
    logic        prot_on, wr_pass;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    int   m_step  = 0;
    logic m_burst = 1'b0;
    logic m_prot  = 1'b0;

    always #5 clk = ~clk;

    swp_seq u_dut (
        .clk(clk), .rst(rst), .nv_clr(nv_clr), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_timeout(load_timeout),
        .prot_on(prot_on), .wr_pass(wr_pass)
    );

    function automatic logic is_pair(logic [12:0] a, logic [7:0] d, logic [12:0] ca, logic [7:0] cd);
        return (a == ca) && (d == cd);
    endfunction

    function automatic logic exp_pass(logic stb, logic to);
        return stb && (!m_prot || (m_burst && !to));
    endfunction

    task automatic model_step(logic stb, logic [12:0] a, logic [7:0] d, logic to);
        int   s = to ? 0 : m_step;
        logic b = m_burst && !to;
        if (stb) begin
            int nxt = is_pair(a, d, 13'h1555, 8'hAA) ? 1 : 0;
            case (s)
                1: if (is_pair(a, d, 13'h0AAA, 8'h55)) nxt = 2;
                2: if (is_pair(a, d, 13'h1555, 8'hA0)) begin nxt = 0; m_prot = 1'b1; b = 1'b1; end
                   else if (is_pair(a, d, 13'h1555, 8'h80)) nxt = 3;
                3: if (is_pair(a, d, 13'h1555, 8'hAA)) nxt = 4;
                4: if (is_pair(a, d, 13'h0AAA, 8'h55)) nxt = 5;
                5: if (is_pair(a, d, 13'h1555, 8'h20)) begin nxt = 0; m_prot = 1'b0; end
                default: ;
            endcase
            s = nxt;
        end
        m_step  = s;
        m_burst = b;
    endtask

    task automatic check(logic act, logic exp, string req, string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(logic stb, logic [12:0] a, logic [7:0] d, logic to, string req);
        logic ep;
        @(negedge clk);
        wr_stb = stb; wr_addr = a; wr_data = d; load_timeout = to;
        #1;
        ep = exp_pass(stb, to);
        check(wr_pass, ep, req, "wr_pass");
        @(posedge clk);
        model_step(stb, a, d, to);
        #1;
        check(prot_on, m_prot, req, "prot_on");
    endtask

    task automatic wr(logic [12:0] a, logic [7:0] d, string req);
        cyc(1'b1, a, d, 1'b0, req);
    endtask

    task automatic tmo(string req);
        cyc(1'b0, 13'h0, 8'h0, 1'b1, req);
    endtask

    task automatic do_rst(string req);
        @(negedge clk);
        rst = 1'b1; wr_stb = 1'b0; load_timeout = 1'b0;
        @(posedge clk);
        m_step = 0; m_burst = 1'b0;
        #1;
        check(prot_on, m_prot, req, "prot_on after rst");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic enable_seq(string req);
        wr(13'h1555, 8'hAA, req);
        wr(13'h0AAA, 8'h55, req);
        wr(13'h1555, 8'hA0, req);
    endtask

    task automatic disable_seq(string req);
        wr(13'h1555, 8'hAA, req);
        wr(13'h0AAA, 8'h55, req);
        wr(13'h1555, 8'h80, req);
        wr(13'h1555, 8'hAA, req);
        wr(13'h0AAA, 8'h55, req);
        wr(13'h1555, 8'h20, req);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0013));
        // power-on clear and tracker reset
        @(negedge clk);
        nv_clr = 1'b1; rst = 1'b1;
        @(posedge clk);
        m_prot = 1'b0; m_step = 0; m_burst = 1'b0;
        #1;
        check(prot_on, 1'b0, "R1", "prot_on after nv_clr");
        @(negedge clk);
        nv_clr = 1'b0; rst = 1'b0;

        // R8: unprotected, data and command writes pass
        wr(13'h0123, 8'h3C, "R8");
        wr(13'h1555, 8'hAA, "R8");
        tmo("R6");
        // R9: idle cycle
        cyc(1'b0, 13'h1555, 8'hAA, 1'b0, "R9");

        // R2: arm with no data following
        enable_seq("R2");
        check(prot_on, 1'b1, "R2", "prot_on after arm");
        tmo("R6");
        wr(13'h0040, 8'h11, "R2");   // blocked: burst closed
        check(prot_on, 1'b1, "R2", "prot held");

        // R3: preamble opens a burst until timeout
        enable_seq("R3");
        wr(13'h0200, 8'h5A, "R3");
        wr(13'h0201, 8'hA5, "R3");
        tmo("R3");
        wr(13'h0202, 8'h77, "R3");

        // R5: broken preamble, then the stray third command
        wr(13'h1555, 8'hAA, "R5");
        wr(13'h0AAA, 8'h55, "R5");
        wr(13'h0100, 8'h12, "R5");
        wr(13'h1555, 8'hA0, "R5");
        wr(13'h0101, 8'h13, "R5");
        // R5: mismatch that is itself the first key restarts
        tmo("R5");
        wr(13'h1555, 8'hAA, "R5");
        wr(13'h1555, 8'hAA, "R5");
        wr(13'h0AAA, 8'h55, "R5");
        wr(13'h1555, 8'hA0, "R5");
        wr(13'h0300, 8'h01, "R5");
        tmo("R5");

        // R6: timeout in the middle of the preamble
        wr(13'h1555, 8'hAA, "R6");
        wr(13'h0AAA, 8'h55, "R6");
        tmo("R6");
        wr(13'h1555, 8'hA0, "R6");
        wr(13'h0400, 8'h02, "R6");
        // R6: timeout coinciding with a strobe inside an open burst
        enable_seq("R6");
        cyc(1'b1, 13'h0401, 8'h03, 1'b1, "R6");

        // R7: reset keeps protection
        do_rst("R7");
        wr(13'h0402, 8'h04, "R7");

        // R4: disable, then writes pass
        tmo("R4");
        disable_seq("R4");
        check(prot_on, 1'b0, "R4", "prot_on after clear");
        wr(13'h0500, 8'h99, "R4");
        tmo("R4");

        // R7: reset while unprotected also keeps the flag
        do_rst("R7");

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 31);
            if (sel == 0) begin
                do_rst("R7");
            end else if (sel == 1) begin
                enable_seq("R2");
            end else if (sel == 2) begin
                disable_seq("R4");
            end else begin
                logic [12:0] a;
                logic [7:0]  d;
                logic        to = ($urandom_range(0, 7) == 0);
                logic        stb = ($urandom_range(0, 5) != 0);
                case ($urandom_range(0, 2))
                    0: a = 13'h1555;
                    1: a = 13'h0AAA;
                    default: a = 13'($urandom);
                endcase
                case ($urandom_range(0, 5))
                    0: d = 8'hAA;
                    1: d = 8'h55;
                    2: d = 8'hA0;
                    3: d = 8'h80;
                    4: d = 8'h20;
                    default: d = 8'($urandom);
                endcase
                cyc(stb, a, d, to, "R5");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule